// File: doc/BRIEF.md
# Masked Vector Element Broadcast Unit

This block fills a vector destination of up to 512 bits with copies of one scalar taken from a general-purpose register. The element size is 8, 16, 32 or 64 bits. The active vector length is 128, 256 or 512 bits. A per-element writemask chooses which lanes take the scalar. A lane that is not chosen either keeps its old destination contents (merge) or is cleared (zero). Every bit above the active vector length is cleared.

The unit also decodes the opcode byte, the W bit and the spare register-specifier field. From these it derives the element size, and it flags encodings that are illegal. An illegal request still produces a valid strobe with the illegal flag raised, and the registered result keeps its previous value. The datapath is combinational, and one register stage sits behind it. A result appears exactly one clock after a valid request.

Top module: `vbcast_unit`

## Requirements
- R1: Opcode 8'h7A selects 8-bit elements and 8'h7B selects 16-bit elements. Opcode 8'h7C selects 32-bit elements when `w_bit` is 0 and 64-bit elements when it is 1. Every written lane holds the low element-size bits of `scalar_in`, and lane j occupies result bits [j*ES +: ES].
- R2: `vlen_sel` encodes 0 as 128, 1 as 256 and 2 as 512 bits. The lane count is the vector length divided by the element size.
- R3: With `mask_en` low, every lane inside the active length is written, whatever `lane_mask` holds.
- R4: With `mask_en` high, lane j is written when `lane_mask[j]` is 1.
- R5: With `mask_en` high and `zero_mode` low, a lane whose mask bit is 0 takes the matching bits of `old_dst`.
- R6: With `mask_en` high and `zero_mode` high, a lane whose mask bit is 0 becomes all zeros.
- R7: Result bits from the active vector length up to bit 511 are zero on every legal result.
- R8: A `spare_reg` value other than 4'b1111 raises `out_illegal`, and `out_result` keeps its previous value.
- R9: `vlen_sel` = 2'b11 is reserved. It raises `out_illegal` and leaves `out_result` unchanged.
- R10: An opcode outside 8'h7A..8'h7C raises `out_illegal` and leaves `out_result` unchanged.
- R11: `out_valid` is high exactly one cycle after each cycle with `in_valid` high. `out_illegal` is only high together with `out_valid`. A synchronous active-high `rst` clears `out_valid`, `out_illegal` and `out_result`.
- R12: Bits of `lane_mask` at or above the active lane count have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| opcode | input | 8 | Opcode byte |
| w_bit | input | 1 | Width bit, picks 32 or 64 bits for opcode 8'h7C |
| spare_reg | input | 4 | Unused register-specifier field, must be 4'b1111 |
| vlen_sel | input | 2 | Vector length: 0=128, 1=256, 2=512, 3 reserved |
| mask_en | input | 1 | Writemask in use |
| zero_mode | input | 1 | 1 clears unselected lanes, 0 merges them |
| lane_mask | input | 64 | Per-element write mask, bit j for lane j |
| scalar_in | input | 64 | Scalar source |
| old_dst | input | 512 | Previous destination contents |
| out_valid | output | 1 | Result strobe |
| out_illegal | output | 1 | Illegal encoding flag |
| out_result | output | 512 | Registered destination value |

## Verification
A wrong element-size decode or a wrong lane-to-mask-bit mapping shows up as a misplaced scalar copy or a wrongly kept lane. It appears in `out_result` one clock after the request, so each request is compared against an independently computed vector at that strobe. A broken active-length bound shows up as nonzero tail bits on the same strobe. A broken illegal path shows up as a changed result while the flag is raised. Mask patterns set bits above the lane count and differ between neighbouring lanes, so an off-by-one in the lane index reaches the ports at once.

// File: rtl/vbc_pkg.sv
package vbc_pkg;

  typedef enum logic [1:0] {
    ESZ_B = 2'd0,
    ESZ_W = 2'd1,
    ESZ_D = 2'd2,
    ESZ_Q = 2'd3
  } esz_e;

  localparam logic [7:0] OPC_BYTE  = 8'h7A;
  localparam logic [7:0] OPC_WORD  = 8'h7B;
  localparam logic [7:0] OPC_DWQW  = 8'h7C;
  localparam logic [3:0] SPARE_OK  = 4'hF;
  localparam logic [1:0] VLEN_RSVD = 2'b11;

  // Number of active bytes for a length code; the reserved code gives none.
  function automatic logic [7:0] active_bytes(input logic [1:0] vlen);
    logic [7:0] n;
    case (vlen)
      2'd0:    n = 8'd16;
      2'd1:    n = 8'd32;
      2'd2:    n = 8'd64;
      default: n = 8'd0;
    endcase
    return n;
  endfunction

  // Number of lanes for a length code and an element size.
  function automatic logic [7:0] lane_count(input logic [1:0] vlen, input esz_e esz);
    return active_bytes(vlen) >> esz;
  endfunction

  // Element index that a byte position belongs to.
  function automatic int unsigned elem_of_byte(input int unsigned b, input esz_e esz);
    return b >> esz;
  endfunction

endpackage

// File: rtl/vbc_decode.sv
module vbc_decode
  import vbc_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic       w_bit,
  input  logic [3:0] spare_reg,
  input  logic [1:0] vlen_sel,
  output esz_e       esz,
  output logic       bad_op,
  output logic       bad_spare,
  output logic       bad_len,
  output logic       illegal
);

  always_comb begin
    bad_op = 1'b0;
    esz    = ESZ_B;
    case (opcode)
      OPC_BYTE: esz = ESZ_B;
      OPC_WORD: esz = ESZ_W;
      OPC_DWQW: esz = w_bit ? ESZ_Q : ESZ_D;
      default:  bad_op = 1'b1;
    endcase
  end

  assign bad_spare = (spare_reg != SPARE_OK);
  assign bad_len   = (vlen_sel == VLEN_RSVD);
  assign illegal   = bad_op | bad_spare | bad_len;

endmodule

// File: rtl/vbc_lane_ctl.sv
module vbc_lane_ctl
  import vbc_pkg::*;
#(
  parameter int NBYTES = 64,
  parameter int MASKW  = 64
) (
  input  esz_e              esz,
  input  logic [1:0]        vlen_sel,
  input  logic              mask_en,
  input  logic              zero_mode,
  input  logic [MASKW-1:0]  lane_mask,
  output logic [NBYTES-1:0] byte_active,
  output logic [NBYTES-1:0] byte_wr,
  output logic [NBYTES-1:0] byte_keep
);

  localparam int IDXW = (MASKW > 1) ? $clog2(MASKW) : 1;

  logic [7:0] act_bytes;
  assign act_bytes = active_bytes(vlen_sel);

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam int BI = b;
    logic [IDXW-1:0] eidx;
    logic            sel;

    always_comb begin
      case (esz)
        ESZ_B:   eidx = IDXW'(BI);
        ESZ_W:   eidx = IDXW'(BI >> 1);
        ESZ_D:   eidx = IDXW'(BI >> 2);
        default: eidx = IDXW'(BI >> 3);
      endcase
    end

    assign byte_active[b] = (8'(BI) < act_bytes);
    assign sel            = mask_en ? lane_mask[eidx] : 1'b1;
    assign byte_wr[b]     = byte_active[b] & sel;
    assign byte_keep[b]   = byte_active[b] & ~sel & ~zero_mode;

    always_comb begin
      AST_WR_KEEP_EXCL: assert (!(byte_wr[b] && byte_keep[b])); // R5
    end
  end

endmodule

// File: rtl/vbc_fill.sv
module vbc_fill
  import vbc_pkg::*;
#(
  parameter int NBYTES = 64,
  parameter int SW     = 64
) (
  input  esz_e                esz,
  input  logic [SW-1:0]       scalar_in,
  input  logic [NBYTES*8-1:0] old_dst,
  input  logic [NBYTES-1:0]   byte_wr,
  input  logic [NBYTES-1:0]   byte_keep,
  output logic [NBYTES*8-1:0] fill_out
);

  localparam int SBYTES = SW / 8;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam int BI = b;
    logic [7:0] rep;

    always_comb begin
      case (esz)
        ESZ_B:   rep = scalar_in[7:0];
        ESZ_W:   rep = scalar_in[(BI % 2) * 8 +: 8];
        ESZ_D:   rep = scalar_in[(BI % 4) * 8 +: 8];
        default: rep = scalar_in[(BI % SBYTES) * 8 +: 8];
      endcase
    end

    assign fill_out[BI*8 +: 8] = byte_wr[b]   ? rep :
                                 byte_keep[b] ? old_dst[BI*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/vbcast_unit.sv
module vbcast_unit
  import vbc_pkg::*;
#(
  parameter int MAXVL = 512,
  parameter int SW    = 64,
  parameter int MASKW = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       opcode,
  input  logic             w_bit,
  input  logic [3:0]       spare_reg,
  input  logic [1:0]       vlen_sel,
  input  logic             mask_en,
  input  logic             zero_mode,
  input  logic [MASKW-1:0] lane_mask,
  input  logic [SW-1:0]    scalar_in,
  input  logic [MAXVL-1:0] old_dst,
  output logic             out_valid,
  output logic             out_illegal,
  output logic [MAXVL-1:0] out_result
);

  localparam int NBYTES = MAXVL / 8;

  esz_e              dec_esz;
  logic              dec_bad_op, dec_bad_spare, dec_bad_len, dec_illegal;
  logic [NBYTES-1:0] byte_active, byte_wr, byte_keep;
  logic [MAXVL-1:0]  fill_out;
  logic              take_result;

  vbc_decode u_dec (
    .opcode    (opcode),
    .w_bit     (w_bit),
    .spare_reg (spare_reg),
    .vlen_sel  (vlen_sel),
    .esz       (dec_esz),
    .bad_op    (dec_bad_op),
    .bad_spare (dec_bad_spare),
    .bad_len   (dec_bad_len),
    .illegal   (dec_illegal)
  );

  vbc_lane_ctl #(.NBYTES(NBYTES), .MASKW(MASKW)) u_lane (
    .esz         (dec_esz),
    .vlen_sel    (vlen_sel),
    .mask_en     (mask_en),
    .zero_mode   (zero_mode),
    .lane_mask   (lane_mask),
    .byte_active (byte_active),
    .byte_wr     (byte_wr),
    .byte_keep   (byte_keep)
  );

  vbc_fill #(.NBYTES(NBYTES), .SW(SW)) u_fill (
    .esz       (dec_esz),
    .scalar_in (scalar_in),
    .old_dst   (old_dst),
    .byte_wr   (byte_wr),
    .byte_keep (byte_keep),
    .fill_out  (fill_out)
  );

  assign take_result = in_valid & ~dec_illegal;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_result  <= '0;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid & dec_illegal;
      if (take_result) out_result <= fill_out;
    end
  end

  AST_ILL_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> out_valid); // R11

  AST_OUT_FOLLOWS_IN: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid)); // R11

  AST_ILL_HOLDS_RESULT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> $stable(out_result)); // R8

  AST_TAIL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_illegal) |->
      ((out_result >> (8 * int'(active_bytes($past(vlen_sel))))) == '0)); // R7

endmodule

// File: tb/vbcast_unit_bench.sv
module vbcast_unit_bench;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [7:0]   opcode;
  logic         w_bit;
  logic [3:0]   spare_reg;
  logic [1:0]   vlen_sel;
  logic         mask_en;
  logic         zero_mode;
  logic [63:0]  lane_mask;
  logic [63:0]  scalar_in;
  logic [511:0] old_dst;
  logic         out_valid;
  logic         out_illegal;
  logic [511:0] out_result;

  always #5 clk = ~clk;

  vbcast_unit u_vbcast_unit (
    .clk, .rst, .in_valid, .opcode, .w_bit, .spare_reg, .vlen_sel,
    .mask_en, .zero_mode, .lane_mask, .scalar_in, .old_dst,
    .out_valid, .out_illegal, .out_result
  );

  typedef struct {
    bit           ill;
    logic [511:0] res;
    string        req;
  } exp_t;

  exp_t         sb_q[$];
  logic [511:0] model_res;
  int           n_checks = 0;
  int           n_bad    = 0;
  bit           done     = 1'b0;

  // Bit-level model written straight from the requirements.
  task automatic drive(input logic [7:0] op, input bit w, input logic [3:0] sp,
                       input logic [1:0] vl, input bit men, input bit zm,
                       input logic [63:0] msk, input logic [63:0] sc,
                       input logic [511:0] od, input string req);
    exp_t e;
    int   es = 0;
    int   vbits;
    e.ill = 1'b0;
    if (op == 8'h7A) es = 8;
    else if (op == 8'h7B) es = 16;
    else if (op == 8'h7C) es = w ? 64 : 32;
    else e.ill = 1'b1;
    if (sp != 4'hF) e.ill = 1'b1;
    if (vl == 2'b11) e.ill = 1'b1;
    if (e.ill) begin
      e.res = model_res;
    end else begin
      vbits = 128 << vl;
      e.res = '0;
      for (int k = 0; k < vbits; k++) begin
        if (!men || msk[k / es]) e.res[k] = sc[k % es];
        else if (!zm)            e.res[k] = od[k];
      end
      model_res = e.res;
    end
    e.req = req;
    @(negedge clk);
    in_valid = 1'b1; opcode = op; w_bit = w; spare_reg = sp; vlen_sel = vl;
    mask_en = men; zero_mode = zm; lane_mask = msk; scalar_in = sc; old_dst = od;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // Monitor: pops one expected item per strobe.
  always @(negedge clk) begin
    if (!rst && !done && out_valid) begin
      n_checks++;
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL R11 unexpected strobe: actual out_valid=1 expected 0");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (out_illegal !== e.ill || out_result !== e.res) begin
          n_bad++;
          $display("FAIL %s: actual ill=%0b res=%h expected ill=%0b res=%h",
                   e.req, out_illegal, out_result, e.ill, e.res);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    logic [511:0] od;
    rst = 1'b1; in_valid = 1'b0; opcode = 8'h00; w_bit = 1'b0; spare_reg = 4'hF;
    vlen_sel = 2'd0; mask_en = 1'b0; zero_mode = 1'b0; lane_mask = '0;
    scalar_in = '0; old_dst = '0; model_res = '0;
    repeat (3) @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || out_illegal !== 1'b0 || out_result !== '0) begin
      n_bad++;
      $display("FAIL R11 reset: actual v=%0b i=%0b res=%h expected all zero",
               out_valid, out_illegal, out_result);
    end
    rst = 1'b0;
    od = rnd512();

    // R1 R2 R3: each element size, unmasked, with a nonzero old destination
    drive(8'h7A, 0, 4'hF, 2'd0, 0, 0, 64'h0, 64'h1122334455667788, od, "R1/R3 byte vl128");
    drive(8'h7B, 0, 4'hF, 2'd1, 0, 1, 64'h0, 64'hA1B2C3D4E5F60718, od, "R1/R2 word vl256");
    drive(8'h7C, 0, 4'hF, 2'd2, 0, 0, 64'h0, 64'hDEADBEEF0BADF00D, od, "R1/R2 dword vl512");
    drive(8'h7C, 1, 4'hF, 2'd2, 0, 0, 64'h0, 64'h0123456789ABCDEF, od, "R1/R2 qword vl512");
    // R12 R5: merge qword with high mask bits set beyond two lanes
    drive(8'h7C, 1, 4'hF, 2'd0, 1, 0, 64'hFFFF_FFFF_FFFF_FFF1, 64'hCAFEF00DCAFEF00D, od, "R12/R5 merge high mask bits");
    // R4 R5: byte merge alternating mask, full length
    drive(8'h7A, 0, 4'hF, 2'd2, 1, 0, 64'hAAAA_5555_F0F0_0F0F, 64'h00000000000000C3, od, "R4/R5 byte merge");
    // R6: word zeroing
    drive(8'h7B, 0, 4'hF, 2'd1, 1, 1, 64'h0000_0000_0000_C3A5, 64'h0000000000007E81, od, "R6 word zeroing");
    // R7: dword vl128 with an all-ones old destination
    drive(8'h7C, 0, 4'hF, 2'd0, 1, 0, 64'hFFFF_FFFF_FFFF_FFF6, 64'h0000000012345678, {512{1'b1}}, "R7 tail cleared");
    idle(3);
    // R8 R9 R10: illegal encodings keep the result
    drive(8'h7A, 0, 4'hE, 2'd0, 0, 0, 64'h0, 64'hFFFFFFFFFFFFFFFF, od, "R8 bad spare");
    drive(8'h7B, 0, 4'hF, 2'd3, 0, 0, 64'h0, 64'h5555555555555555, od, "R9 reserved length");
    drive(8'h7D, 0, 4'hF, 2'd1, 0, 0, 64'h0, 64'h3333333333333333, od, "R10 opcode above range");
    drive(8'h79, 1, 4'hF, 2'd2, 0, 0, 64'h0, 64'h7777777777777777, od, "R10 opcode below range");
    drive(8'h7C, 1, 4'h0, 2'd2, 1, 1, 64'hFF, 64'h9999999999999999, od, "R8 spare zero");
    idle(2);
    // R11: back-to-back stream with varied settings
    for (int i = 0; i < 40; i++) begin
      logic [7:0] op;
      logic [1:0] vl;
      op = 8'h7A + 8'($urandom_range(0, 2));
      vl = 2'($urandom_range(0, 2));
      drive(op, 1'($urandom), 4'hF, vl, 1'($urandom), 1'($urandom),
            {$urandom, $urandom}, {$urandom, $urandom}, rnd512(), "R11 stream");
    end
    idle(4);
    n_checks++;
    if (sb_q.size() != 0 || out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 drain: actual pending=%0d valid=%0b expected 0 0",
               sb_q.size(), out_valid);
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule